// File: doc/BRIEF.md
# Progressive Read-Retry Level Sequencer

This controller runs one flash page read at a time through rising soft-sensing precision until an external error-correction decoder accepts the data. A request carries a page address, a stored start level and a mode bit. The controller then loops. It issues a sense command at the current level to an external sensing port, together with the number of reference voltages for that level. It waits for a pass or fail verdict from the external decoder. After each fail it moves up one level, and after a pass it stops.

In baseline mode every read starts at level 1. In latency-aware mode the read starts at the level remembered for that page, so a page that needed heavy sensing last time skips the cheaper levels that would fail anyway. When the read finishes, the block reports:

- the level that succeeded;
- how many sense attempts were spent;
- whether the read failed even at the top level.

When the read succeeds at a level other than the one it started from, the block also raises an update strobe carrying the new level, so that the stored level can be rewritten. The flash array, the soft-information generation and the decoder are outside the block and are reached through valid/ready handshakes.

Top module: `rrl_seq`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. Any request presented while a read is in progress is ignored and does not change that read's results.
- R2: The first sense level is 1 when `req_aware` is 0. It is `req_start_lvl` when `req_aware` is 1 and that value lies in 1..7. A start value of 0 or of 8..15 is treated as 1.
- R3: `sense_valid` stays high until `sense_ready` is seen. While it waits, `sense_lvl`, `sense_refv` and `sense_page` do not change. `sense_page` equals the page of the accepted request.
- R4: While `sense_valid` is high, `sense_refv` equals 3 × `sense_lvl`.
- R5: A fail verdict (`dec_ok`=0) below level 7 raises the level by exactly one and issues a new sense command in the next cycle. A pass verdict ends the read.
- R6: `done_valid` is a single-cycle pulse. With it, `done_lvl` gives the last sensed level and `done_tries` gives the number of sense commands accepted for the request.
- R7: `upd_valid` is high together with `done_valid` exactly when the read passed at a level different from its effective start level. `upd_lvl` then equals `done_lvl`. Otherwise `upd_valid` stays low.
- R8: A fail verdict at level 7 ends the read with `done_uncorr`=1 and `done_lvl`=7, and no update strobe is raised.
- R9: After a synchronous active-low reset, even one in the middle of a read, the block is idle: `req_ready`=1, and `sense_valid`, `dec_ready`, `done_valid` and `upd_valid` are all 0.
- R10: `dec_ready` is high only while no sense command is pending. Exactly one verdict is taken per accepted sense command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_page | input | PAGE_W | Page address of the request |
| req_start_lvl | input | LVL_W+1 | Stored start level (clamped) |
| req_aware | input | 1 | 1: start at stored level, 0: start at level 1 |
| sense_valid | output | 1 | Sense command pending |
| sense_ready | input | 1 | Sensing port takes the command |
| sense_page | output | PAGE_W | Page to sense |
| sense_lvl | output | LVL_W | Current read level |
| sense_refv | output | REFV_W | Reference voltage count, 3 × level |
| dec_valid | input | 1 | Decoder verdict present |
| dec_ready | output | 1 | Block waiting for a verdict |
| dec_ok | input | 1 | Verdict: 1 pass, 0 fail |
| done_valid | output | 1 | One-cycle completion strobe |
| done_lvl | output | LVL_W | Final level |
| done_tries | output | TRY_W | Sense attempts spent |
| done_uncorr | output | 1 | Failed at the top level |
| upd_valid | output | 1 | Stored level needs rewriting |
| upd_lvl | output | LVL_W | New level to store |

## Verification
Every result has a fixed cycle. A request accepted at one rising edge raises `sense_valid` in the next cycle. A sense accepted at an edge opens the verdict wait one cycle later. A verdict taken at an edge produces either the next sense command or the `done_valid` pulse in the following cycle. The bench drives all inputs and reads all outputs on falling edges, so it always sees the state that the previous rising edge settled. It answers each sense and verdict as it arrives and computes the expected final level, attempt count, uncorrectable flag and update strobe from the start level, the mode and the level at which its decoder model starts passing. It also checks that the pulse is gone one falling edge later.

// File: rtl/rrl_pkg.sv
// Shared types for the read-retry level sequencer.
package rrl_pkg;
    // Controller states; one request is in flight at a time.
    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_SENSE  = 2'd1,
        RS_DECODE = 2'd2,
        RS_DONE   = 2'd3
    } rrl_state_e;
endpackage

// File: rtl/rrl_start_sel.sv
// Picks the effective first read level.
// Assumes: start_raw is one bit wider than a level so out-of-range values are visible.
module rrl_start_sel #(
    parameter int MAX_LVL = 7,
    parameter int LVL_W   = 3
) (
    input  logic [LVL_W:0]   start_raw,
    input  logic             aware,
    output logic [LVL_W-1:0] eff_lvl
);
    // Baseline mode or an out-of-range stored level both fall back to level 1.
    always_comb begin
        if (aware && (start_raw != '0) && (start_raw <= (LVL_W+1)'(MAX_LVL)))
            eff_lvl = start_raw[LVL_W-1:0];
        else
            eff_lvl = LVL_W'(1);
    end
endmodule

// File: rtl/rrl_level_reg.sv
// Holds the current read level and the level the request started from.
// Assumes: load and step are never high together; step is ignored at the top level.
module rrl_level_reg #(
    parameter int MAX_LVL = 7,
    parameter int LVL_W   = 3,
    parameter int REFV_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LVL_W-1:0]  load_lvl,
    input  logic              step,
    output logic [LVL_W-1:0]  lvl,
    output logic              at_max,
    output logic              moved,
    output logic [REFV_W-1:0] refv
);
    logic [LVL_W-1:0] start_q;

    // Load on request acceptance, climb one level on each failed verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl     <= LVL_W'(1);
            start_q <= LVL_W'(1);
        end else if (load) begin
            lvl     <= load_lvl;
            start_q <= load_lvl;
        end else if (step && !at_max) begin
            lvl     <= lvl + LVL_W'(1);
        end
    end

    // Top-level detect, change detect and reference voltage count.
    always_comb begin
        at_max = (lvl == LVL_W'(MAX_LVL));
        moved  = (lvl != start_q);
        refv   = REFV_W'(lvl) * REFV_W'(3);
    end
endmodule

// File: rtl/rrl_try_cnt.sv
// Counts accepted sense commands for one request; saturates at all ones.
// Assumes: clear and inc are never high together.
module rrl_try_cnt #(
    parameter int TRY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [TRY_W-1:0] cnt
);
    // Reset or clear to zero, step on each accepted sense command.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt <= '0;
        else if (inc && (cnt != {TRY_W{1'b1}}))
            cnt <= cnt + TRY_W'(1);
    end
endmodule

// File: rtl/rrl_ctrl_fsm.sv
// Sequencing state machine: idle, sense handshake, verdict wait, result pulse.
// Assumes: the sense port and the decoder each answer through their own valid/ready pair.
module rrl_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic sense_ready,
    input  logic dec_valid,
    input  logic dec_ok,
    input  logic at_max,
    output logic req_ready,
    output logic sense_valid,
    output logic dec_ready,
    output logic done_valid,
    output logic uncorr,
    output logic load,
    output logic step,
    output logic cnt_clr,
    output logic cnt_inc
);
    import rrl_pkg::*;

    rrl_state_e state_q, state_d;
    logic       set_unc;

    // Next state and one-cycle control strobes.
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        set_unc = 1'b0;
        case (state_q)
            RS_IDLE: begin
                if (req_valid) begin
                    load    = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = RS_SENSE;
                end
            end
            RS_SENSE: begin
                if (sense_ready) begin
                    cnt_inc = 1'b1;
                    state_d = RS_DECODE;
                end
            end
            RS_DECODE: begin
                if (dec_valid) begin
                    if (dec_ok) begin
                        state_d = RS_DONE;
                    end else if (at_max) begin
                        set_unc = 1'b1;
                        state_d = RS_DONE;
                    end else begin
                        step    = 1'b1;
                        state_d = RS_SENSE;
                    end
                end
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Uncorrectable flag, cleared on each new request.
    always_ff @(posedge clk) begin
        if (!rst_n || load) uncorr <= 1'b0;
        else if (set_unc)   uncorr <= 1'b1;
    end

    // Handshake outputs decoded from the state.
    always_comb begin
        req_ready   = (state_q == RS_IDLE);
        sense_valid = (state_q == RS_SENSE);
        dec_ready   = (state_q == RS_DECODE);
        done_valid  = (state_q == RS_DONE);
    end
endmodule

// File: rtl/rrl_seq.sv
// Top of the progressive read-retry level sequencer.
// Assumes: one request at a time; sensing and decoding are external.
module rrl_seq #(
    parameter int  PAGE_W  = 16,
    parameter int  MAX_LVL = 7,
    localparam int LVL_W   = $clog2(MAX_LVL + 1),
    localparam int REFV_W  = $clog2(3 * MAX_LVL + 1),
    localparam int TRY_W   = $clog2(MAX_LVL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PAGE_W-1:0] req_page,
    input  logic [LVL_W:0]    req_start_lvl,
    input  logic              req_aware,
    output logic              sense_valid,
    input  logic              sense_ready,
    output logic [PAGE_W-1:0] sense_page,
    output logic [LVL_W-1:0]  sense_lvl,
    output logic [REFV_W-1:0] sense_refv,
    input  logic              dec_valid,
    output logic              dec_ready,
    input  logic              dec_ok,
    output logic              done_valid,
    output logic [LVL_W-1:0]  done_lvl,
    output logic [TRY_W-1:0]  done_tries,
    output logic              done_uncorr,
    output logic              upd_valid,
    output logic [LVL_W-1:0]  upd_lvl
);
    logic [LVL_W-1:0]  eff_lvl, lvl;
    logic              at_max, moved, uncorr;
    logic              load, step, cnt_clr, cnt_inc;
    logic [TRY_W-1:0]  tries;
    logic [PAGE_W-1:0] page_q;

    rrl_start_sel #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W)) u_start (
        .start_raw (req_start_lvl),
        .aware     (req_aware),
        .eff_lvl   (eff_lvl)
    );

    rrl_level_reg #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W), .REFV_W(REFV_W)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_lvl (eff_lvl),
        .step     (step),
        .lvl      (lvl),
        .at_max   (at_max),
        .moved    (moved),
        .refv     (sense_refv)
    );

    rrl_try_cnt #(.TRY_W(TRY_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (tries)
    );

    rrl_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .sense_ready (sense_ready),
        .dec_valid   (dec_valid),
        .dec_ok      (dec_ok),
        .at_max      (at_max),
        .req_ready   (req_ready),
        .sense_valid (sense_valid),
        .dec_ready   (dec_ready),
        .done_valid  (done_valid),
        .uncorr      (uncorr),
        .load        (load),
        .step        (step),
        .cnt_clr     (cnt_clr),
        .cnt_inc     (cnt_inc)
    );

    // Capture the page address when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    page_q <= '0;
        else if (load) page_q <= req_page;
    end

    // Result and update outputs, qualified by the completion pulse.
    always_comb begin
        sense_page  = page_q;
        sense_lvl   = lvl;
        done_lvl    = lvl;
        done_tries  = tries;
        done_uncorr = done_valid && uncorr;
        upd_valid   = done_valid && !uncorr && moved;
        upd_lvl     = lvl;
    end
endmodule

// File: rtl/rrl_seq_chk.sv
// Port-level protocol checks for rrl_seq, attached with bind.
module rrl_seq_chk #(
    parameter int MAX_LVL = 7,
    parameter int LVL_W   = 3,
    parameter int REFV_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              sense_valid,
    input logic              sense_ready,
    input logic [LVL_W-1:0]  sense_lvl,
    input logic [REFV_W-1:0] sense_refv,
    input logic              dec_valid,
    input logic              dec_ready,
    input logic              dec_ok,
    input logic              done_valid,
    input logic [LVL_W-1:0]  done_lvl,
    input logic              done_uncorr,
    input logic              upd_valid,
    input logic [LVL_W-1:0]  upd_lvl
);
    // R1
    idle_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!sense_valid && !dec_ready && !done_valid));

    // R2
    lvl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_valid |-> (sense_lvl >= LVL_W'(1) && sense_lvl <= LVL_W'(MAX_LVL)));

    // R3
    sense_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_valid && !sense_ready) |=>
            (sense_valid && $stable(sense_lvl) && $stable(sense_refv)));

    // R4
    refv_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sense_valid |-> (REFV_W'(sense_refv) == REFV_W'(sense_lvl) * REFV_W'(3)));

    // R5
    fail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ready && !dec_ok && sense_lvl != LVL_W'(MAX_LVL)) |=>
            (sense_valid && sense_lvl == LVL_W'($past(sense_lvl) + LVL_W'(1))));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R7
    upd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (done_valid && !done_uncorr && upd_lvl == done_lvl));

    // R8
    uncorr_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_uncorr |-> (done_lvl == LVL_W'(MAX_LVL) && !upd_valid));

    // R10
    dec_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ready |-> !sense_valid);
endmodule

bind rrl_seq rrl_seq_chk #(.MAX_LVL(MAX_LVL), .LVL_W(LVL_W), .REFV_W(REFV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .sense_valid (sense_valid),
    .sense_ready (sense_ready),
    .sense_lvl   (sense_lvl),
    .sense_refv  (sense_refv),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_ok      (dec_ok),
    .done_valid  (done_valid),
    .done_lvl    (done_lvl),
    .done_uncorr (done_uncorr),
    .upd_valid   (upd_valid),
    .upd_lvl     (upd_lvl)
);

// File: tb/tb_rrl_seq.sv
module tb_rrl_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_page = '0;
    logic [3:0]  req_start_lvl = '0;
    logic        req_aware = 1'b0;
    logic        sense_valid;
    logic        sense_ready = 1'b0;
    logic [15:0] sense_page;
    logic [2:0]  sense_lvl;
    logic [4:0]  sense_refv;
    logic        dec_valid = 1'b0;
    logic        dec_ready;
    logic        dec_ok = 1'b0;
    logic        done_valid;
    logic [2:0]  done_lvl;
    logic [2:0]  done_tries;
    logic        done_uncorr;
    logic        upd_valid;
    logic [2:0]  upd_lvl;

    int  total = 0;
    int  bad = 0;
    bit  ended = 1'b0;

    rrl_seq dut (.*);

    always #4 clk = ~clk;

    // Vector fields: {start[3:0], aware, pass_level[3:0] (8 = never passes), stall[1:0]}
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {4'd1,  1'b0, 4'd1, 2'd0},
        {4'd5,  1'b0, 4'd3, 2'd0},
        {4'd4,  1'b1, 4'd2, 2'd0},
        {4'd3,  1'b1, 4'd6, 2'd2},
        {4'd0,  1'b1, 4'd2, 2'd0},
        {4'd9,  1'b1, 4'd1, 2'd1},
        {4'd1,  1'b0, 4'd8, 2'd0},
        {4'd6,  1'b1, 4'd8, 2'd1},
        {4'd7,  1'b1, 4'd7, 2'd0},
        {4'd15, 1'b1, 4'd4, 2'd3}
    };

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic run_case(input logic [3:0] st, input logic aw, input int ps,
                            input int stall, input bit poke, input logic [15:0] pg);
        int  eff, exp_lvl, exp_tries, seen, waitc, last, decs;
        bit  exp_unc, exp_upd, got;
        eff = (aw && st >= 1 && st <= 7) ? int'(st) : 1;
        if (ps <= eff) begin
            exp_lvl = eff; exp_unc = 1'b0;
        end else if (ps <= 7) begin
            exp_lvl = ps;  exp_unc = 1'b0;
        end else begin
            exp_lvl = 7;   exp_unc = 1'b1;
        end
        exp_tries = exp_lvl - eff + 1;
        exp_upd   = !exp_unc && (exp_lvl != eff);

        @(negedge clk);
        chk(req_ready == 1'b1, "R1 idle ready", int'(req_ready), 1);
        req_valid = 1'b1; req_start_lvl = st; req_aware = aw; req_page = pg;
        seen = 0; waitc = 0; last = 0; decs = 0; got = 1'b0;
        for (int c = 0; c < 300 && !got; c++) begin
            @(negedge clk);
            if (poke) begin
                req_valid = 1'b1; req_start_lvl = 4'd7; req_aware = 1'b1; req_page = ~pg;
            end else begin
                req_valid = 1'b0;
            end
            if (done_valid) begin
                got = 1'b1;
                req_valid = 1'b0; sense_ready = 1'b0; dec_valid = 1'b0;
                chk(done_lvl == 3'(exp_lvl), "R6 final level", int'(done_lvl), exp_lvl);
                chk(done_tries == 3'(exp_tries), "R6 attempt count", int'(done_tries), exp_tries);
                chk(done_uncorr == exp_unc, "R8 uncorrectable flag", int'(done_uncorr), int'(exp_unc));
                chk(upd_valid == exp_upd, "R7 update strobe", int'(upd_valid), int'(exp_upd));
                if (exp_upd)
                    chk(upd_lvl == 3'(exp_lvl), "R7 update level", int'(upd_lvl), exp_lvl);
                chk(decs == exp_tries, "R10 one verdict per sense", decs, exp_tries);
            end else begin
                if (req_ready) chk(1'b0, "R1 busy but ready", 1, 0);
                if (sense_valid) begin
                    if (waitc < stall) begin
                        sense_ready = 1'b0;
                        waitc++;
                    end else begin
                        chk(sense_lvl == 3'(eff + seen), "R5 R2 sense level order",
                            int'(sense_lvl), eff + seen);
                        chk(sense_refv == 5'(3 * (eff + seen)), "R4 reference voltage count",
                            int'(sense_refv), 3 * (eff + seen));
                        chk(sense_page == pg, "R3 sense page", int'(sense_page), int'(pg));
                        sense_ready = 1'b1;
                        waitc = 0;
                        last = int'(sense_lvl);
                        seen++;
                    end
                end else begin
                    sense_ready = 1'b0;
                end
                if (dec_ready) decs++;
                dec_valid = dec_ready;
                dec_ok    = (last >= ps);
            end
        end
        if (!got) chk(1'b0, "R6 completion timeout", 0, 1);
        @(negedge clk);
        chk(done_valid == 1'b0, "R6 done is one cycle", int'(done_valid), 0);
        chk(req_ready == 1'b1 && sense_valid == 1'b0, "R1 back to idle",
            int'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9 reset ready", int'(req_ready), 1);
        chk(!sense_valid && !dec_ready, "R9 reset handshakes low", int'(sense_valid), 0);
        chk(!done_valid && !upd_valid, "R9 reset results low", int'(done_valid), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_case(VEC[i][10:7], VEC[i][6], int'(VEC[i][5:2]), int'(VEC[i][1:0]),
                     1'b0, 16'(16'h1000 + i));
        end

        // R1: a request held high during a read is ignored
        run_case(4'd2, 1'b1, 4, 1, 1'b1, 16'hBEEF);

        // R9: reset in the middle of a read
        @(negedge clk);
        req_valid = 1'b1; req_start_lvl = 4'd3; req_aware = 1'b1; req_page = 16'h0042;
        @(negedge clk);
        req_valid = 1'b0;
        chk(sense_valid == 1'b1, "R2 sense after accept", int'(sense_valid), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && !sense_valid, "R9 mid-read reset idles",
            int'(req_ready), 1);
        chk(!done_valid && !upd_valid && !dec_ready, "R9 mid-read reset outputs low",
            int'(done_valid), 0);
        rst_n = 1'b1;

        // After reset the block runs normally again
        run_case(4'd5, 1'b1, 6, 0, 1'b0, 16'h0077);

        summary();
    end
endmodule